// File: doc/BRIEF.md
# DES Initial-Permutation Step Datapath

This block is a single custom-instruction execution step for a 32-bit processor pipeline. It implements one fixed operation. The first operand has its low nibbles moved into the high nibble of the same byte. The second operand passes through a hard-wired bit gatherer, and only the low nibbles of the gathered value are kept. The two halves are merged by OR, and the result is captured in an output register, so a valid result appears one clock after the request.

The operation is built so that software can compute the whole 64-bit DES initial permutation with four issues of this step and two ordinary 1-bit right shifts. Take a 64-bit block whose most significant bit is DES bit 1. Let `lo` be its low 32 bits and `hi` its high 32 bits.

- The first output word (DES output bits 1..32) is `step(step(0, lo), hi)`.
- The second output word (DES output bits 33..64) is `step(step(0, lo >> 1), hi >> 1)`.

The sequence works because every 16-bit chunk of the permutation uses the same bit-gathering pattern. The other chunks differ only by a 1-bit offset, and that offset is supplied by the shifts between the two pairs of issues.

Top module: `desip_step`

## Requirements
- R1: While `rst` is high, `out_valid` is 0 and `result` is 0 at every clock edge.
- R2: `out_valid` is high exactly one cycle after a cycle with `in_valid` high, and low one cycle after a cycle with `in_valid` low.
- R3: For each byte, result bits [8n+7:8n+4] equal `rs1` bits [8n+3:8n] of the request. The high nibbles of `rs1` (mask 0xF0F0F0F0) have no effect on the result.
- R4: For a bit position p whose position within its byte (p mod 8) is 0..3, result bit p equals `rs2` bit (24 - 8*(p mod 8) + 2*(p div 8)). Examples: result bit 0 takes `rs2` bit 24, and result bit 27 takes `rs2` bit 6.
- R5: The odd-numbered bits of `rs2` (mask 0xAAAAAAAA) have no effect on the result.
- R6: When `in_valid` is low, `result` keeps its previous value whatever `rs1` and `rs2` carry.
- R7: The sequence `step(step(0, lo), hi)` yields DES initial-permutation output bits 1..32 (bit 1 in result bit 31). For input 0x0123456789ABCDEF this gives 0xCC00CCFF.
- R8: The sequence `step(step(0, lo >> 1), hi >> 1)` yields DES initial-permutation output bits 33..64. For input 0x0123456789ABCDEF this gives 0xF0AAF0AA.
- R9: Requests may be issued on every consecutive cycle. Each one produces its own result, in issue order, one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe for one step |
| rs1 | input | 32 | Operand whose low nibbles fill the result's high nibbles |
| rs2 | input | 32 | Operand fed through the fixed bit gatherer |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 32 | Registered step result |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a 4-bit nibble move, and the two complementary nibble masks. This is the configuration in which chaining four steps reproduces the full 64-bit permutation. With these values the bench can compare both output words against a table model of the standard permutation, for a known vector and for random blocks. It can also reach the single-bit gather positions, the ignored operand bits, and back-to-back issue against a scoreboard queue.

// File: rtl/desip_step_pkg.sv
package desip_step_pkg;

  localparam int WORD_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int NIB_W   = 4;

  // Source bit of the second operand feeding result bit p.
  // Only low-nibble positions matter; other positions pass straight through
  // and are discarded by the low-nibble mask downstream.
  function automatic int gather_src(input int p);
    int lane;
    int row;
    lane = p % BYTE_W;
    row  = p / BYTE_W;
    if (lane < NIB_W)
      return 24 - BYTE_W * lane + 2 * row;
    else
      return p;
  endfunction

endpackage

// File: rtl/desip_gather.sv
module desip_gather #(
  parameter int DATA_W = desip_step_pkg::WORD_W
) (
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  // One wire per output bit: a fixed crossbar picking every eighth even bit.
  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    localparam int SRC = desip_step_pkg::gather_src(g);
    assign dout[g] = din[SRC];
  end

endmodule

// File: rtl/desip_merge.sv
module desip_merge #(
  parameter int              DATA_W  = desip_step_pkg::WORD_W,
  parameter int              SHIFT   = desip_step_pkg::NIB_W,
  parameter logic [DATA_W-1:0] HI_MASK = 32'hF0F0_F0F0,
  parameter logic [DATA_W-1:0] LO_MASK = 32'h0F0F_0F0F
) (
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] gathered,
  output logic [DATA_W-1:0] merged
);

  logic [DATA_W-1:0] acc_moved;
  logic [DATA_W-1:0] hi_part;
  logic [DATA_W-1:0] lo_part;

  always_comb begin
    acc_moved = acc << SHIFT;
    hi_part   = acc_moved & HI_MASK;
    lo_part   = gathered & LO_MASK;
    merged    = hi_part | lo_part;
  end

endmodule

// File: rtl/desip_outreg.sv
module desip_outreg #(
  parameter int DATA_W = desip_step_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vin,
  input  logic [DATA_W-1:0] din,
  output logic              vout,
  output logic [DATA_W-1:0] dout
);

  always_ff @(posedge clk) begin
    if (rst) begin
      vout <= 1'b0;
      dout <= '0;
    end else begin
      vout <= vin;
      if (vin)
        dout <= din;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!vout && dout == '0));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst) vin |=> vout);

  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst) !vin |=> !vout);

  // R6
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst) !vin |=> $stable(dout));

endmodule

// File: rtl/desip_step.sv
module desip_step #(
  parameter int                DATA_W  = desip_step_pkg::WORD_W,
  parameter int                SHIFT   = desip_step_pkg::NIB_W,
  parameter logic [DATA_W-1:0] HI_MASK = 32'hF0F0_F0F0,
  parameter logic [DATA_W-1:0] LO_MASK = 32'h0F0F_0F0F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] rs1,
  input  logic [DATA_W-1:0] rs2,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);

  logic [DATA_W-1:0] gathered;
  logic [DATA_W-1:0] merged;

  desip_gather #(
    .DATA_W (DATA_W)
  ) u_gather (
    .din  (rs2),
    .dout (gathered)
  );

  desip_merge #(
    .DATA_W  (DATA_W),
    .SHIFT   (SHIFT),
    .HI_MASK (HI_MASK),
    .LO_MASK (LO_MASK)
  ) u_merge (
    .acc      (rs1),
    .gathered (gathered),
    .merged   (merged)
  );

  desip_outreg #(
    .DATA_W (DATA_W)
  ) u_outreg (
    .clk  (clk),
    .rst  (rst),
    .vin  (in_valid),
    .din  (merged),
    .vout (out_valid),
    .dout (result)
  );

  // R3
  hi_nibble_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ((result & HI_MASK) == (($past(rs1) << SHIFT) & HI_MASK)));

  // R4
  lane0_gather_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (result[0] == $past(rs2[24])));

endmodule

// File: tb/desip_step_bench.sv
module desip_step_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] rs1 = '0;
  logic [31:0] rs2 = '0;
  logic        out_valid;
  logic [31:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] exp_q[$];

  always #10 clk = ~clk;

  desip_step u_desip_step (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .rs1       (rs1),
    .rs2       (rs2),
    .out_valid (out_valid),
    .result    (result)
  );

  // Spec model of one step, from R3 and R4.
  function automatic logic [31:0] step_model(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    for (int p = 0; p < 32; p++) begin
      if ((p % 8) >= 4) r[p] = a[p-4];
      else              r[p] = b[24 - 8*(p % 8) + 2*(p / 8)];
    end
    return r;
  endfunction

  // Standard DES initial permutation, bit 1 = MSB.
  function automatic logic [63:0] ref_ip(input logic [63:0] v);
    logic [63:0] o;
    for (int i = 1; i <= 64; i++) begin
      int blk;
      int pos;
      int col;
      int src;
      blk = (i - 1) / 8;
      pos = (i - 1) % 8;
      col = (blk < 4) ? (2*blk + 2) : (2*(blk - 4) + 1);
      src = 8*(7 - pos) + col;
      o[64-i] = v[64-src];
    end
    return o;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: scoreboard compare on every produced result (R3, R4, R9).
  always @(negedge clk) begin
    if (!rst && out_valid && !done) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected out_valid", 64'd1, 64'd0);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        check("R3,R4 scoreboard", {32'd0, result}, {32'd0, e});
      end
    end
  end

  task automatic op(input logic [31:0] a, input logic [31:0] b, output logic [31:0] r);
    @(negedge clk);
    rs1 = a;
    rs2 = b;
    in_valid = 1'b1;
    exp_q.push_back(step_model(a, b));
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 valid after one cycle", {63'd0, out_valid}, 64'd1);
    r = result;
  endtask

  task automatic ip_forward(input logic [63:0] v, output logic [31:0] w1, output logic [31:0] w2);
    logic [31:0] t;
    op(32'd0, v[31:0], t);
    op(t, v[63:32], w1);
    op(32'd0, v[31:0] >> 1, t);
    op(t, v[63:32] >> 1, w2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, r2, w1, w2;
    logic [31:0] a, b;
    logic [63:0] v, e;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", {63'd0, out_valid}, 64'd0);
    check("R1 result in reset", {32'd0, result}, 64'd0);
    rst = 1'b0;

    // R2: idle gives no valid
    repeat (3) @(negedge clk);
    check("R2 idle no valid", {63'd0, out_valid}, 64'd0);

    // R3: low nibbles of rs1 land in high nibbles
    op(32'h0F0F_0F0F, 32'd0, r);
    check("R3 nibble move", {32'd0, r}, 64'hF0F0_F0F0);
    op(32'hF0F0_F0F0, 32'd0, r);
    check("R3 high nibbles ignored", {32'd0, r}, 64'd0);

    // R4: gather positions
    op(32'd0, 32'h5555_5555, r);
    check("R4 all even bits", {32'd0, r}, 64'h0F0F_0F0F);
    op(32'd0, 32'h0100_0000, r);
    check("R4 bit24 to bit0", {32'd0, r}, 64'h0000_0001);
    op(32'd0, 32'h0000_0040, r);
    check("R4 bit6 to bit27", {32'd0, r}, 64'h0800_0000);

    // R5: odd rs2 bits ignored
    op(32'd0, 32'hAAAA_AAAA, r);
    check("R5 odd bits only", {32'd0, r}, 64'd0);
    for (int k = 0; k < 8; k++) begin
      a = $urandom;
      b = $urandom;
      op(a, b, r);
      op(a, b ^ 32'hAAAA_AAAA, r2);
      check("R5 odd flip no effect", {32'd0, r2}, {32'd0, r});
      op(a ^ 32'hF0F0_F0F0, b, r2);
      check("R3 rs1 high flip no effect", {32'd0, r2}, {32'd0, r});
    end

    // R6: hold while idle
    op(32'h1234_5678, 32'h9ABC_DEF0, r);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      rs1 = $urandom;
      rs2 = $urandom;
    end
    check("R6 result held", {32'd0, result}, {32'd0, r});

    // R7, R8: known vector
    ip_forward(64'h0123_4567_89AB_CDEF, w1, w2);
    check("R7 known first word", {32'd0, w1}, 64'h0000_0000_CC00_CCFF);
    check("R8 known second word", {32'd0, w2}, 64'h0000_0000_F0AA_F0AA);

    // R7, R8: random blocks vs table model
    for (int k = 0; k < 20; k++) begin
      v = {$urandom, $urandom};
      e = ref_ip(v);
      ip_forward(v, w1, w2);
      check("R7 random first word", {32'd0, w1}, {32'd0, e[63:32]});
      check("R8 random second word", {32'd0, w2}, {32'd0, e[31:0]});
    end

    // R9: back-to-back issue
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      rs1 = $urandom;
      rs2 = $urandom;
      in_valid = 1'b1;
      exp_q.push_back(step_model(rs1, rs2));
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 all streamed results seen", {32'd0, exp_q.size()}, 64'd0);
    check("R2 valid drops after burst", {63'd0, out_valid}, 64'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule